// File: doc/BRIEF.md
# Receive Bit Error Rate Checker

This block checks a recovered serial bit stream against a known test pattern. Each bit arrives with a qualifying enable. The block can invert the bit, then compares it with a reference that is either a 2^15-1 pseudorandom sequence (polynomial x^15+x^14+1) or a programmable word that repeats every 17 to 32 bits. The block first hunts for alignment with the stream and then declares lock. While locked, it counts the bits it receives and the bits that disagree with the reference. A burst of errors drops it back into hunting.

Software sets the mode, the inversion controls, the repeating word, its length and three interrupt masks through a flat write port. Three sticky status flags record counter saturation, a detected bit error and any change of lock state. Software clears a flag by writing 1 to its position. The interrupt output is the OR of the flags that are enabled. A transmit-invert control bit is passed straight out so that a paired generator can use it. Any write to the control or pattern register restarts the hunt.

Top module: `bert_rx_checker`

## Requirements
- R1: With control bit 0 (receive invert) set, every received bit is complemented before comparison. An inverted pseudorandom stream therefore locks only when this bit is 1 and never locks when it is 0.
- R2: Output tx_invert equals control bit 1 from the cycle after the control write.
- R3: With control bit 2 at 0 (pseudorandom mode), the first 15 valid bits after a restart seed the reference. Each later bit is compared with reference bit 14 XOR bit 13. On a clean stream, lock is declared on the 47th valid bit and not on the 46th.
- R4: The 4-bit length code in control bits 6:3 has no effect in pseudorandom mode. Lock timing is unchanged for any code.
- R5: With control bit 2 at 1 (repetitive mode), the pattern length is the code plus 17, and pattern register bit i is expected at stream position i mod length. A stream aligned to bit 0 locks on valid bit 2×length and not one bit earlier.
- R6: In repetitive mode, a failed comparison during hunting rotates the reference by one extra bit. A stream starting at any phase eventually locks. A short pattern held as a whole multiple in the register checks without errors, and a corrupted bit is counted.
- R7: While locked, the sixth error within any 64 consecutive valid bits drops lock on that bit, and five such errors do not. In pseudorandom mode, lock returns on the 47th clean bit after the loss.
- R8: The bit counter increments once per valid bit and the error counter once per mismatching bit, only when lock was held at that bit. Both counters hold their values while the block is hunting.
- R9: Both counters saturate at all ones. Status bit 0 is set when either counter reaches all ones.
- R10: Status bit 1 is set by an error counted while locked. Status bit 2 is set whenever lock is gained or lost.
- R11: Writing register 2 clears each status bit written as 1. irq is high when any status bit is set whose enable is set: control bit 8 for bit 0, bit 9 for bit 1, bit 10 for bit 2.
- R12: A write to register 0 (control) or register 1 (pattern) drops lock and restarts hunting on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered serial data bit |
| rx_bit_en | input | 1 | Qualifies rx_bit for this cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 pattern, 2 status clear |
| cfg_wdata | input | 32 | Register write data |
| tx_invert | output | 1 | Transmit-invert control for a paired generator |
| locked | output | 1 | Checker is aligned to the stream |
| bit_count | output | CNT_W | Saturating count of bits received while locked |
| err_count | output | CNT_W | Saturating count of bit errors received while locked |
| status | output | 3 | Sticky flags: 0 saturation, 1 bit error, 2 lock change |
| irq | output | 1 | Interrupt, OR of enabled status flags |

## Verification
The embedded assertions check the following on every cycle: lock is only ever lost through an error or a restart, lock is only ever gained on a clean comparison, each counter steps by exactly one per counted event and stays put once saturated, and neither counter moves while lock is absent. The error flag is also checked to rise only on a counted error. The exact cycle at which lock is gained (47 bits in pseudorandom mode, twice the length in repetitive mode) can only be shown by the bench's scenarios. The same holds for the effect of receive inversion, the five-versus-six error boundary, the masking of the interrupt, and recovery from an arbitrary starting phase.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int unsigned LEN_BASE  = 17;
    localparam int unsigned CODE_W    = 4;
    localparam int unsigned FLAG_W    = 3;
    localparam int unsigned FLG_OVF   = 0;
    localparam int unsigned FLG_ERR   = 1;
    localparam int unsigned FLG_SYNC  = 2;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PAT  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_st_t;

    typedef struct packed {
        logic              ie_sync;
        logic              ie_err;
        logic              ie_ovf;
        logic [CODE_W-1:0] len_code;
        logic              rep_mode;
        logic              tx_inv;
        logic              rx_inv;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.rx_inv   = w[0];
        c.tx_inv   = w[1];
        c.rep_mode = w[2];
        c.len_code = w[6:3];
        c.ie_ovf   = w[8];
        c.ie_err   = w[9];
        c.ie_sync  = w[10];
        return c;
    endfunction

    function automatic logic [5:0] code_to_len(input logic [CODE_W-1:0] code);
        return 6'(LEN_BASE) + 6'(code);
    endfunction

endpackage

// File: rtl/bert_prbs_ref.sv
module bert_prbs_ref #(
    parameter int unsigned W      = 15,
    parameter int unsigned TAP_HI = 14,
    parameter int unsigned TAP_LO = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    input  logic locked,
    input  logic d,
    output logic ready,
    output logic mismatch
);
    localparam int unsigned FW = $clog2(W + 1);
    localparam logic [FW-1:0] FULL = FW'(W);

    logic [W-1:0]  sr_q;
    logic [FW-1:0] fill_q;
    logic          pred;

    assign ready    = (fill_q == FULL);
    assign pred     = sr_q[TAP_HI] ^ sr_q[TAP_LO];
    assign mismatch = ready && (d != pred);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (en) begin
            if (locked) begin
                sr_q <= {sr_q[W-2:0], pred};
            end else begin
                sr_q <= {sr_q[W-2:0], d};
                if (!ready) fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bert_rep_ref.sv
module bert_rep_ref #(
    parameter int unsigned PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          restart,
    input  logic          locked,
    input  logic          d,
    input  logic [PW-1:0] pattern,
    input  logic [5:0]    len,
    output logic          mismatch
);
    localparam int unsigned IW = $clog2(PW);

    logic [IW-1:0] idx_q;
    logic [IW:0]   step1, step2;
    logic [IW-1:0] nxt1, nxt2;

    assign mismatch = (d != pattern[idx_q]);

    always_comb begin
        step1 = {1'b0, idx_q} + 1'b1;
        step2 = {1'b0, idx_q} + 2'd2;
        nxt1  = (step1 >= (IW+1)'(len)) ? IW'(step1 - (IW+1)'(len)) : IW'(step1);
        nxt2  = (step2 >= (IW+1)'(len)) ? IW'(step2 - (IW+1)'(len)) : IW'(step2);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx_q <= '0;
        end else if (en) begin
            if (!locked && mismatch) idx_q <= nxt2;
            else                     idx_q <= nxt1;
        end
    end

endmodule

// File: rtl/bert_sync.sv
module bert_sync
    import bert_pkg::*;
#(
    parameter int unsigned TGT_W = 7,
    parameter int unsigned WIN   = 64,
    parameter int unsigned LOSS  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic             cmp_valid,
    input  logic             mismatch,
    input  logic [TGT_W-1:0] target,
    output logic             locked,
    output logic             gain,
    output logic             lose
);
    sync_st_t         st_q, st_n;
    logic [TGT_W-1:0] good_q, good_n;
    logic [WIN-1:0]   hist_q, hist_n;

    assign locked = (st_q == ST_LOCK);

    always_comb begin
        st_n   = st_q;
        good_n = good_q;
        hist_n = hist_q;
        if (restart) begin
            st_n   = ST_HUNT;
            good_n = '0;
            hist_n = '0;
        end else if (en) begin
            if (st_q == ST_HUNT) begin
                if (cmp_valid) begin
                    if (mismatch) begin
                        good_n = '0;
                    end else if (good_q + 1'b1 == target) begin
                        st_n   = ST_LOCK;
                        good_n = '0;
                    end else begin
                        good_n = good_q + 1'b1;
                    end
                end
            end else begin
                hist_n = {hist_q[WIN-2:0], mismatch};
                if ($countones(hist_n) >= LOSS) begin
                    st_n   = ST_HUNT;
                    hist_n = '0;
                end
            end
        end
    end

    assign gain = (st_q == ST_HUNT) && (st_n == ST_LOCK);
    assign lose = (st_q == ST_LOCK) && (st_n == ST_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            good_q <= '0;
            hist_q <= '0;
        end else begin
            st_q   <= st_n;
            good_q <= good_n;
            hist_q <= hist_n;
        end
    end

    // R7: lock is only lost through an error or a restart
    assert_loss_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(restart || (en && mismatch)));

    // R3: lock is only gained on a clean comparison
    assert_gain_clean_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(en && cmp_valid && !mismatch && !restart));

endmodule

// File: rtl/bert_counters.sv
module bert_counters #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   inc,
    output logic [W-1:0] bit_count,
    output logic [W-1:0] err_count,
    output logic [1:0]   hit_max
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)                            cnt_q[g] <= '0;
            else if (inc[g] && cnt_q[g] != MAXV) cnt_q[g] <= cnt_q[g] + 1'b1;
        end

        assign hit_max[g] = inc[g] && (cnt_q[g] == MAXV - 1'b1);

        // R8: one step per counted event
        assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
            (inc[g] && cnt_q[g] != MAXV) |=> cnt_q[g] == $past(cnt_q[g]) + 1'b1);

        // R9: saturation holds
        assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (cnt_q[g] == MAXV) |=> cnt_q[g] == MAXV);
    end

    assign bit_count = cnt_q[0];
    assign err_count = cnt_q[1];

endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker
    import bert_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned PAT_W     = 32,
    parameter int unsigned LOCK_RUN  = 32,
    parameter int unsigned PRBS_W    = 15,
    parameter int unsigned LOSS_WIN  = 64,
    parameter int unsigned LOSS_ERRS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_bit,
    input  logic             rx_bit_en,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic             tx_invert,
    output logic             locked,
    output logic [CNT_W-1:0] bit_count,
    output logic [CNT_W-1:0] err_count,
    output logic [2:0]       status,
    output logic             irq
);
    localparam int unsigned TGT_W = $clog2(2 * PAT_W + 1);

    ctrl_t             ctrl_q;
    logic [PAT_W-1:0]  pat_q;
    logic [FLAG_W-1:0] flags_q, flag_set, flag_en;

    logic wr_ctrl, wr_pat, wr_stat, cfg_restart;
    logic d;
    logic prbs_ready, prbs_miss, rep_miss;
    logic mismatch, cmp_valid;
    logic gain, lose;
    logic count_bit, count_err;
    logic [1:0] hit_max;
    logic [5:0] pat_len;
    logic [TGT_W-1:0] target;

    assign wr_ctrl     = cfg_we && (cfg_addr == ADDR_CTRL);
    assign wr_pat      = cfg_we && (cfg_addr == ADDR_PAT);
    assign wr_stat     = cfg_we && (cfg_addr == ADDR_STAT);
    assign cfg_restart = wr_ctrl || wr_pat;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pat_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= unpack_ctrl(cfg_wdata);
            if (wr_pat)  pat_q  <= cfg_wdata[PAT_W-1:0];
        end
    end

    assign d       = rx_bit ^ ctrl_q.rx_inv;
    assign pat_len = code_to_len(ctrl_q.len_code);
    assign target  = ctrl_q.rep_mode ? TGT_W'({pat_len, 1'b0}) : TGT_W'(LOCK_RUN);

    bert_prbs_ref #(
        .W      (PRBS_W),
        .TAP_HI (PRBS_W - 1),
        .TAP_LO (PRBS_W - 2)
    ) prbs_i (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_bit_en && !ctrl_q.rep_mode),
        .restart  (cfg_restart || lose),
        .locked   (locked),
        .d        (d),
        .ready    (prbs_ready),
        .mismatch (prbs_miss)
    );

    bert_rep_ref #(
        .PW (PAT_W)
    ) rep_i (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_bit_en && ctrl_q.rep_mode),
        .restart  (cfg_restart),
        .locked   (locked),
        .d        (d),
        .pattern  (pat_q),
        .len      (pat_len),
        .mismatch (rep_miss)
    );

    assign mismatch  = ctrl_q.rep_mode ? rep_miss : prbs_miss;
    assign cmp_valid = ctrl_q.rep_mode || prbs_ready;

    bert_sync #(
        .TGT_W (TGT_W),
        .WIN   (LOSS_WIN),
        .LOSS  (LOSS_ERRS)
    ) sync_i (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_bit_en),
        .restart   (cfg_restart),
        .cmp_valid (cmp_valid),
        .mismatch  (mismatch),
        .target    (target),
        .locked    (locked),
        .gain      (gain),
        .lose      (lose)
    );

    assign count_bit = locked && rx_bit_en;
    assign count_err = count_bit && mismatch;

    bert_counters #(
        .W (CNT_W)
    ) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .inc       ({count_err, count_bit}),
        .bit_count (bit_count),
        .err_count (err_count),
        .hit_max   (hit_max)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_OVF]  = |hit_max;
        flag_set[FLG_ERR]  = count_err;
        flag_set[FLG_SYNC] = gain || lose;
        flag_en            = '0;
        flag_en[FLG_OVF]   = ctrl_q.ie_ovf;
        flag_en[FLG_ERR]   = ctrl_q.ie_err;
        flag_en[FLG_SYNC]  = ctrl_q.ie_sync;
    end

    always_ff @(posedge clk) begin
        if (rst)          flags_q <= '0;
        else if (wr_stat) flags_q <= (flags_q & ~cfg_wdata[FLAG_W-1:0]) | flag_set;
        else              flags_q <= flags_q | flag_set;
    end

    assign status    = flags_q;
    assign irq       = |(flags_q & flag_en);
    assign tx_invert = ctrl_q.tx_inv;

    // R10: the error flag rises only on an error counted under lock
    assert_err_flag_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(status[FLG_ERR]) |-> $past(locked && rx_bit_en && mismatch));

    // R8: counters hold while hunting
    assert_no_count_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
        !locked |=> ($stable(bit_count) && $stable(err_count)));

endmodule

// File: tb/bert_rx_checker_tb_top.sv
`timescale 1ns/1ps
module bert_rx_checker_tb_top;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_bit, rx_bit_en;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [31:0]   cfg_wdata;
    logic          tx_invert, locked, irq;
    logic [CW-1:0] bit_count, err_count;
    logic [2:0]    status;

    always #10 clk = ~clk;

    bert_rx_checker #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_invert(tx_invert), .locked(locked), .bit_count(bit_count),
        .err_count(err_count), .status(status), .irq(irq)
    );

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } exp_item_t;

    exp_item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [14:0] gen_sr;
    int          rep_pos;
    logic [5:0]  short_pat = 6'b101100;

    function automatic logic [31:0] probe(int sel);
        case (sel)
            0: return {31'd0, locked};
            1: return 32'(bit_count);
            2: return 32'(err_count);
            3: return {29'd0, status};
            4: return {31'd0, irq};
            default: return {31'd0, tx_invert};
        endcase
    endfunction

    function automatic string sel_name(int sel);
        case (sel)
            0: return "locked";
            1: return "bit_count";
            2: return "err_count";
            3: return "status";
            4: return "irq";
            default: return "tx_invert";
        endcase
    endfunction

    // monitor: pops expected items and compares once outputs are settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = probe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%0h expected=%0h", it.tag, sel_name(it.sel), act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string tag, int sel, logic [31:0] v);
        exp_item_t it;
        it.tag = tag; it.sel = sel; it.exp = v;
        exp_q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        rx_bit_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_bit_en = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(logic [1:0] a, logic [31:0] v);
        @(negedge clk);
        rx_bit_en = 1'b0;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // pseudorandom source x^15+x^14+1, optionally inverted, last bit optionally flipped
    task automatic send_prbs(int n, bit inv, bit flip_last);
        for (int i = 0; i < n; i++) begin
            logic nb;
            nb     = gen_sr[14] ^ gen_sr[13];
            gen_sr = {gen_sr[13:0], nb};
            @(negedge clk);
            rx_bit    = nb ^ inv ^ (flip_last && (i == n - 1));
            rx_bit_en = 1'b1;
        end
        settle();
    endtask

    task automatic send_rep(int n, bit flip_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit    = short_pat[rep_pos % 6] ^ (flip_last && (i == n - 1));
            rx_bit_en = 1'b1;
            rep_pos++;
        end
        settle();
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] pat;
        rst = 1'b1; rx_bit = 1'b0; rx_bit_en = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        gen_sr = 15'h1ACE;
        do_reset();
        settle();
        expect_val("reset R8", 0, 0);
        expect_val("reset R8", 1, 0);
        expect_val("reset R10", 3, 0);
        expect_val("reset R11", 4, 0);

        // pseudorandom, tx invert, code 1010 ignored, ie_ovf and ie_sync enabled
        cfg_write(2'd0, 32'h552);
        settle();
        expect_val("R2 tx_invert set", 5, 1);
        send_prbs(46, 1'b0, 1'b0);
        expect_val("R3 R4 no lock at 46", 0, 0);
        send_prbs(1, 1'b0, 1'b0);
        expect_val("R3 R4 lock at 47", 0, 1);
        expect_val("R10 sync flag on gain", 3, 3'b100);
        expect_val("R11 irq sync enabled", 4, 1);
        send_prbs(10, 1'b0, 1'b0);
        expect_val("R8 bit count", 1, 10);
        expect_val("R8 no errors", 2, 0);
        cfg_write(2'd2, 32'h7);
        settle();
        expect_val("R11 w1c clears", 3, 0);
        expect_val("R11 irq low", 4, 0);

        // five spaced errors keep lock
        for (int k = 0; k < 5; k++) send_prbs(10, 1'b0, 1'b1);
        expect_val("R7 five errors keep lock", 0, 1);
        expect_val("R8 error count", 2, 5);
        expect_val("R8 bit count", 1, 60);
        expect_val("R10 err flag", 3, 3'b010);
        expect_val("R11 err masked", 4, 0);
        send_prbs(1, 1'b0, 1'b1);
        expect_val("R7 sixth error drops lock", 0, 0);
        expect_val("R8 sixth error counted", 2, 6);
        expect_val("R8 bit count", 1, 61);
        expect_val("R10 sync flag on loss", 3, 3'b110);
        expect_val("R11 irq sync", 4, 1);
        cfg_write(2'd2, 32'h7);
        send_prbs(46, 1'b0, 1'b0);
        expect_val("R7 no relock at 46", 0, 0);
        expect_val("R8 hold while hunting", 1, 61);
        send_prbs(1, 1'b0, 1'b0);
        expect_val("R7 relock at 47", 0, 1);
        cfg_write(2'd2, 32'h7);

        // saturation with the narrow bench counter
        send_prbs(193, 1'b0, 1'b0);
        expect_val("R9 count 254", 1, 254);
        expect_val("R9 no flag yet", 3, 0);
        send_prbs(1, 1'b0, 1'b0);
        expect_val("R9 count max", 1, 255);
        expect_val("R9 ovf flag", 3, 3'b001);
        expect_val("R11 irq ovf", 4, 1);
        send_prbs(5, 1'b0, 1'b0);
        expect_val("R9 saturated", 1, 255);

        // receive inversion
        do_reset();
        cfg_write(2'd0, 32'h0);
        settle();
        expect_val("R2 tx_invert clear", 5, 0);
        send_prbs(100, 1'b1, 1'b0);
        expect_val("R1 inverted stream no lock", 0, 0);
        cfg_write(2'd0, 32'h1);
        send_prbs(46, 1'b1, 1'b0);
        expect_val("R1 inverted not yet", 0, 0);
        send_prbs(1, 1'b1, 1'b0);
        expect_val("R1 inverted lock", 0, 1);

        // repetitive mode, 6-bit pattern held three times in 18 bits
        do_reset();
        pat = '0;
        for (int i = 0; i < 18; i++) pat[i] = short_pat[i % 6];
        cfg_write(2'd1, pat);
        cfg_write(2'd0, 32'hC);
        rep_pos = 0;
        send_rep(35, 1'b0);
        expect_val("R5 no lock at 35", 0, 0);
        send_rep(1, 1'b0);
        expect_val("R5 lock at 36", 0, 1);
        send_rep(20, 1'b0);
        expect_val("R6 clean short pattern", 2, 0);
        expect_val("R8 rep bit count", 1, 20);
        send_rep(1, 1'b1);
        expect_val("R6 corrupt bit counted", 2, 1);
        cfg_write(2'd0, 32'hC);
        settle();
        expect_val("R12 write drops lock", 0, 0);
        rep_pos = 3;
        send_rep(150, 1'b0);
        expect_val("R6 lock from phase 3", 0, 1);
        send_rep(30, 1'b0);
        expect_val("R6 no errors after lock", 2, 1);

        settle();
        #5;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule